// File: doc/BRIEF.md
# Receive Frame Acceptance Filter

This block sits at the tail of an Ethernet receive path. When the MAC signals the end of a frame, it presents a one-cycle strobe together with a status bundle that describes the frame: its byte length, line and CRC error flags, whether it was cut short by a receive FIFO overflow, whether it is a MAC control or pause frame, its TCP/UDP classification with a checksum-bad flag, and a priority flag. The filter weighs these against a set of per-cause acceptance enables and a checksum policy. One clock later it issues a registered decision: hand the frame to the host or drop it, whether a status report is written, and which of two completion queues receives that report.

The acceptance enables come from the upper nine bits (31 down to 23) of a 32-bit receive control register and arrive on the `ctrl_field` port. Each enable lets through one class of exceptional frame. A frame is kept only when every fault it carries has its enable set. Rejected frames can still be reported to the host when the descriptor format is the long one. High-priority frames can be steered to the second queue. A drop strobe and a drop counter are provided so that statistics logic elsewhere can attach.

Top module: `rx_accept_filter`

## Requirements
- R1: A frame whose length is below 64 bytes is rejected unless `ctrl_field[7]` (register bit 30) is 1. A frame of exactly 64 bytes is never rejected for length.
- R2: A frame flagged with a dribble nibble, a code violation or a FIFO-overflow cut-off is rejected unless `ctrl_field[6]` (register bit 29) is 1.
- R3: A frame with a CRC error is rejected unless `ctrl_field[5]` (register bit 28) is 1.
- R4: A MAC control frame whose `frm_pause` is 0 is rejected unless `ctrl_field[4]` (bit 27) is 1. A pause frame (`frm_pause`=1) is rejected unless `ctrl_field[3]` (bit 26) is 1. Bit 27 has no effect on pause frames.
- R5: The checksum policy `ctrl_field[2:1]` (bits 25:24) works as follows. 00 and 11 ignore `frm_csum_bad`. 01 rejects TCP frames with a bad checksum. 10 rejects both TCP and UDP frames with a bad checksum.
- R6: A frame with several faults is accepted only if each of those faults is enabled. A frame with no fault is always accepted.
- R7: An accepted frame always has `dec_report`=1. A rejected frame has `dec_report`=1 only when `ctrl_field[8]` (bit 31) is 1 and `long_desc_mode` is 1.
- R8: `dec_queue` is 1 (second completion queue) only when `ctrl_field[0]` (bit 23) is 1 and `frm_hi_prio` is 1. Otherwise it is 0 (first queue).
- R9: `dec_valid` goes high for exactly one cycle, in the clock after each cycle in which `eof_valid` is 1. Back-to-back strobes give back-to-back decisions, each computed from the inputs present with its own strobe.
- R10: `drop_pulse` equals `dec_valid` AND NOT `dec_accept`. `drop_count` rises by one with each drop and holds at its all-ones value.
- R11: While `rst_n` is 0, all outputs are 0, and the drop count restarts from 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctrl_field | input | 9 | Control register bits 31:23 (report, short, malformed, CRC, control, pause, checksum policy[1:0], queue-2 enable) |
| long_desc_mode | input | 1 | Long completion descriptor format selected |
| eof_valid | input | 1 | End-of-frame strobe qualifying the status bundle |
| frm_len | input | LEN_W (14) | Frame length in bytes |
| frm_crc_err | input | 1 | CRC check failed |
| frm_dribble | input | 1 | Dribble nibble seen |
| frm_code_viol | input | 1 | Line code violation seen |
| frm_fifo_ovf | input | 1 | Frame truncated by FIFO overflow |
| frm_mac_ctrl | input | 1 | MAC control frame |
| frm_pause | input | 1 | MAC control frame is a pause frame |
| frm_is_tcp | input | 1 | Frame carries TCP |
| frm_is_udp | input | 1 | Frame carries UDP |
| frm_csum_bad | input | 1 | Transport checksum failed |
| frm_hi_prio | input | 1 | Frame classified as high priority |
| dec_valid | output | 1 | Decision strobe |
| dec_accept | output | 1 | Frame goes to the host |
| dec_report | output | 1 | A completion status is written |
| dec_queue | output | 1 | 0 first completion queue, 1 second |
| drop_pulse | output | 1 | Strobe for each rejected frame |
| drop_count | output | CNT_W (16) | Saturating count of rejected frames |

## Verification
The hardest case to reach from the ports is a frame that carries more than one fault when only some of those faults are enabled. Another is a pause frame whose acceptance must ignore the control-frame enable. The vector table pairs the same fault bundle with different enable sets, so that the flip from reject to accept happens exactly where the last missing enable is added. Drop-counter saturation is reached by building the bench with a narrow counter and sending a burst of back-to-back rejected frames after the table.

// File: rtl/rxf_pkg.sv
// Package rxf_pkg
// Shared field positions, cause indices and record types for the receive
// acceptance filter. Assumes the 9-bit control field is register bits 31:23.
package rxf_pkg;

    // Positions inside ctrl_field (register bit = index + 23)
    localparam int CF_REPORT  = 8;
    localparam int CF_SHORT   = 7;
    localparam int CF_MALF    = 6;
    localparam int CF_CRC     = 5;
    localparam int CF_CTRL    = 4;
    localparam int CF_PAUSE   = 3;
    localparam int CF_CSUM_HI = 2;
    localparam int CF_CSUM_LO = 1;
    localparam int CF_Q2      = 0;
    localparam int CF_W       = 9;

    // Reject-cause indices
    localparam int C_SHORT   = 0;
    localparam int C_MALF    = 1;
    localparam int C_CRC     = 2;
    localparam int C_CTRL    = 3;
    localparam int C_PAUSE   = 4;
    localparam int C_CSUM    = 5;
    localparam int NUM_CAUSE = 6;

    typedef enum logic [1:0] {
        CSUM_IGNORE  = 2'b00,
        CSUM_TCP     = 2'b01,
        CSUM_TCP_UDP = 2'b10,
        CSUM_RSVD    = 2'b11
    } csum_mode_e;

    typedef struct packed {
        logic crc_err;
        logic dribble;
        logic code_viol;
        logic fifo_ovf;
        logic mac_ctrl;
        logic pause;
        logic is_tcp;
        logic is_udp;
        logic csum_bad;
        logic hi_prio;
    } frm_status_t;

    typedef struct packed {
        logic accept;
        logic report;
        logic queue;
    } decision_t;

endpackage

// File: rtl/rxf_csum_policy.sv
// Module rxf_csum_policy
// Decides whether the transport checksum policy rejects a frame.
// Assumes is_tcp and is_udp are not both set; the reserved mode acts as ignore.
module rxf_csum_policy
    import rxf_pkg::*;
(
    input  logic [1:0] mode,
    input  logic       is_tcp,
    input  logic       is_udp,
    input  logic       csum_bad,
    output logic       csum_reject
);

    csum_mode_e mode_e;

    // Map the raw field onto the policy enumeration
    always_comb mode_e = csum_mode_e'(mode);

    // Select the protocols the current policy holds to their checksum
    always_comb begin
        unique case (mode_e)
            CSUM_TCP:     csum_reject = csum_bad & is_tcp;
            CSUM_TCP_UDP: csum_reject = csum_bad & (is_tcp | is_udp);
            default:      csum_reject = 1'b0;
        endcase
    end

endmodule

// File: rtl/rxf_cause_decode.sv
// Module rxf_cause_decode
// Turns a frame status bundle into a vector of reject causes, one bit per
// class of exceptional frame. Purely combinational; the caller qualifies it.
module rxf_cause_decode
    import rxf_pkg::*;
#(
    parameter int LEN_W   = 14,
    parameter int MIN_LEN = 64
) (
    input  logic [LEN_W-1:0]     len,
    input  frm_status_t          st,
    input  logic [1:0]           csum_mode,
    output logic [NUM_CAUSE-1:0] cause
);

    localparam logic [LEN_W-1:0] MIN_LEN_V = LEN_W'(MIN_LEN);

    logic csum_rej;

    rxf_csum_policy u_csum (
        .mode        (csum_mode),
        .is_tcp      (st.is_tcp),
        .is_udp      (st.is_udp),
        .csum_bad    (st.csum_bad),
        .csum_reject (csum_rej)
    );

    // Classify each fault of the frame into its cause slot
    always_comb begin
        cause          = '0;
        cause[C_SHORT] = (len < MIN_LEN_V);
        cause[C_MALF]  = st.dribble | st.code_viol | st.fifo_ovf;
        cause[C_CRC]   = st.crc_err;
        cause[C_CTRL]  = st.mac_ctrl & ~st.pause;
        cause[C_PAUSE] = st.pause;
        cause[C_CSUM]  = csum_rej;
    end

endmodule

// File: rtl/rxf_accept_logic.sv
// Module rxf_accept_logic
// Masks the reject causes with the acceptance enables and forms the
// accept / report / queue triple. Assumes ctrl uses the rxf_pkg layout.
module rxf_accept_logic
    import rxf_pkg::*;
(
    input  logic [NUM_CAUSE-1:0] cause,
    input  logic [CF_W-1:0]      ctrl,
    input  logic                 long_mode,
    input  logic                 hi_prio,
    output decision_t            dec
);

    logic [NUM_CAUSE-1:0] allow;
    logic [NUM_CAUSE-1:0] blocked;
    logic                 reject;

    // Gather the per-cause acceptance enables; the checksum has none
    always_comb begin
        allow          = '0;
        allow[C_SHORT] = ctrl[CF_SHORT];
        allow[C_MALF]  = ctrl[CF_MALF];
        allow[C_CRC]   = ctrl[CF_CRC];
        allow[C_CTRL]  = ctrl[CF_CTRL];
        allow[C_PAUSE] = ctrl[CF_PAUSE];
        allow[C_CSUM]  = 1'b0;
    end

    // One masking slice per cause
    for (genvar i = 0; i < NUM_CAUSE; i++) begin : g_mask
        assign blocked[i] = cause[i] & ~allow[i];
    end

    assign reject = |blocked;

    // Assemble the decision triple
    always_comb begin
        dec.accept = ~reject;
        dec.report = ~reject | (ctrl[CF_REPORT] & long_mode);
        dec.queue  = ctrl[CF_Q2] & hi_prio;
    end

endmodule

// File: rtl/rxf_drop_counter.sv
// Module rxf_drop_counter
// Counts rejected frames. SATURATE selects holding at all-ones (1) or
// wrapping (0). Synchronous active-low reset.
module rxf_drop_counter #(
    parameter int CNT_W    = 16,
    parameter bit SATURATE = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    output logic [CNT_W-1:0] count
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic hold;

    if (SATURATE) begin : g_sat
        assign hold = (count == CNT_MAX);
    end else begin : g_wrap
        assign hold = 1'b0;
    end

    // Advance the count on each drop unless pinned at the ceiling
    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= '0;
        else if (inc && !hold)
            count <= count + 1'b1;
    end

endmodule

// File: rtl/rx_accept_filter.sv
// Module rx_accept_filter
// Registers a drop/accept decision one clock after each end-of-frame strobe.
// Assumes the status bundle and ctrl_field are stable in the strobe cycle.
// Synchronous active-low reset clears every output.
module rx_accept_filter
    import rxf_pkg::*;
#(
    parameter int LEN_W   = 14,
    parameter int MIN_LEN = 64,
    parameter int CNT_W   = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [8:0]       ctrl_field,
    input  logic             long_desc_mode,
    input  logic             eof_valid,
    input  logic [LEN_W-1:0] frm_len,
    input  logic             frm_crc_err,
    input  logic             frm_dribble,
    input  logic             frm_code_viol,
    input  logic             frm_fifo_ovf,
    input  logic             frm_mac_ctrl,
    input  logic             frm_pause,
    input  logic             frm_is_tcp,
    input  logic             frm_is_udp,
    input  logic             frm_csum_bad,
    input  logic             frm_hi_prio,
    output logic             dec_valid,
    output logic             dec_accept,
    output logic             dec_report,
    output logic             dec_queue,
    output logic             drop_pulse,
    output logic [CNT_W-1:0] drop_count
);

    frm_status_t          st;
    logic [NUM_CAUSE-1:0] cause;
    decision_t            dec_nxt;
    decision_t            dec_q;
    logic                 valid_q;
    logic                 drop_q;

    // Pack the status pins into one record
    always_comb begin
        st.crc_err   = frm_crc_err;
        st.dribble   = frm_dribble;
        st.code_viol = frm_code_viol;
        st.fifo_ovf  = frm_fifo_ovf;
        st.mac_ctrl  = frm_mac_ctrl;
        st.pause     = frm_pause;
        st.is_tcp    = frm_is_tcp;
        st.is_udp    = frm_is_udp;
        st.csum_bad  = frm_csum_bad;
        st.hi_prio   = frm_hi_prio;
    end

    rxf_cause_decode #(
        .LEN_W   (LEN_W),
        .MIN_LEN (MIN_LEN)
    ) u_cause (
        .len       (frm_len),
        .st        (st),
        .csum_mode (ctrl_field[CF_CSUM_HI:CF_CSUM_LO]),
        .cause     (cause)
    );

    rxf_accept_logic u_accept (
        .cause     (cause),
        .ctrl      (ctrl_field),
        .long_mode (long_desc_mode),
        .hi_prio   (st.hi_prio),
        .dec       (dec_nxt)
    );

    // Capture the decision in the cycle after the frame end strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            dec_q   <= '0;
            drop_q  <= 1'b0;
        end else begin
            valid_q <= eof_valid;
            dec_q   <= eof_valid ? dec_nxt : '0;
            drop_q  <= eof_valid & ~dec_nxt.accept;
        end
    end

    rxf_drop_counter #(
        .CNT_W    (CNT_W),
        .SATURATE (1'b1)
    ) u_drops (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (eof_valid & ~dec_nxt.accept),
        .count (drop_count)
    );

    assign dec_valid  = valid_q;
    assign dec_accept = dec_q.accept;
    assign dec_report = dec_q.report;
    assign dec_queue  = dec_q.queue;
    assign drop_pulse = drop_q;

endmodule

// File: rtl/rx_accept_filter_chk.sv
// Module rx_accept_filter_chk
// Property checker bound to rx_accept_filter. Watches ports only.
module rx_accept_filter_chk #(
    parameter int LEN_W   = 14,
    parameter int MIN_LEN = 64,
    parameter int CNT_W   = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [8:0]       ctrl_field,
    input logic             long_desc_mode,
    input logic             eof_valid,
    input logic [LEN_W-1:0] frm_len,
    input logic             frm_crc_err,
    input logic             frm_hi_prio,
    input logic             dec_valid,
    input logic             dec_accept,
    input logic             dec_report,
    input logic             dec_queue,
    input logic             drop_pulse,
    input logic [CNT_W-1:0] drop_count
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic past_ok;

    // Marks that one clock has passed since reset was released
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    AST_SHORT_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && dec_valid && ($past(frm_len) < LEN_W'(MIN_LEN)) && !$past(ctrl_field[7])
            |-> !dec_accept); // R1
    AST_CRC_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && dec_valid && $past(frm_crc_err) && !$past(ctrl_field[5])
            |-> !dec_accept); // R3
    AST_ACCEPT_REPORTED: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid && dec_accept |-> dec_report); // R7
    AST_DROP_REPORT_RULE: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && dec_valid && !dec_accept
            |-> dec_report == ($past(ctrl_field[8]) && $past(long_desc_mode))); // R7
    AST_QUEUE_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && dec_valid
            |-> dec_queue == ($past(ctrl_field[0]) && $past(frm_hi_prio))); // R8
    AST_VALID_FOLLOWS_EOF: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> dec_valid == $past(eof_valid)); // R9
    AST_DROP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        drop_pulse == (dec_valid && !dec_accept)); // R10
    AST_DROP_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && drop_pulse && ($past(drop_count) != CNT_MAX)
            |-> drop_count == $past(drop_count) + 1'b1); // R10
    AST_DROP_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && !drop_pulse |-> $stable(drop_count)); // R10

endmodule

bind rx_accept_filter rx_accept_filter_chk #(
    .LEN_W   (LEN_W),
    .MIN_LEN (MIN_LEN),
    .CNT_W   (CNT_W)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .ctrl_field     (ctrl_field),
    .long_desc_mode (long_desc_mode),
    .eof_valid      (eof_valid),
    .frm_len        (frm_len),
    .frm_crc_err    (frm_crc_err),
    .frm_hi_prio    (frm_hi_prio),
    .dec_valid      (dec_valid),
    .dec_accept     (dec_accept),
    .dec_report     (dec_report),
    .dec_queue      (dec_queue),
    .drop_pulse     (drop_pulse),
    .drop_count     (drop_count)
);

// File: tb/rx_accept_filter_tb_top.sv
// Bench for rx_accept_filter: table-driven vectors, then directed tests.
module rx_accept_filter_tb_top;

    localparam int LEN_W = 14;
    localparam int CNT_W = 4;

    // st bits: crc, dribble, codeviol, fifo_ovf, mac_ctrl, pause, tcp, udp, csum_bad, hi
    // exp bits: accept, report, queue
    typedef struct packed {
        logic [3:0]       req;
        logic [8:0]       cf;
        logic             lng;
        logic [LEN_W-1:0] len;
        logic [9:0]       st;
        logic [2:0]       exp;
    } vec_t;

    localparam int NVEC = 25;
    localparam vec_t VECS [NVEC] = '{
        '{4'd6, 9'h000, 1'b0, 14'd100, 10'h000, 3'b110},  // R6 clean frame
        '{4'd1, 9'h000, 1'b0, 14'd63,  10'h000, 3'b000},  // R1 short rejected
        '{4'd1, 9'h080, 1'b0, 14'd63,  10'h000, 3'b110},  // R1 short enabled
        '{4'd1, 9'h000, 1'b0, 14'd64,  10'h000, 3'b110},  // R1 exactly 64
        '{4'd2, 9'h000, 1'b0, 14'd100, 10'h100, 3'b000},  // R2 dribble
        '{4'd2, 9'h040, 1'b0, 14'd100, 10'h040, 3'b110},  // R2 fifo overflow enabled
        '{4'd3, 9'h000, 1'b0, 14'd100, 10'h200, 3'b000},  // R3 crc rejected
        '{4'd3, 9'h020, 1'b0, 14'd100, 10'h200, 3'b110},  // R3 crc enabled
        '{4'd4, 9'h008, 1'b0, 14'd100, 10'h020, 3'b000},  // R4 control, only pause enable
        '{4'd4, 9'h010, 1'b0, 14'd100, 10'h020, 3'b110},  // R4 control enabled
        '{4'd4, 9'h010, 1'b0, 14'd100, 10'h030, 3'b000},  // R4 pause, only control enable
        '{4'd4, 9'h008, 1'b0, 14'd100, 10'h030, 3'b110},  // R4 pause enabled
        '{4'd5, 9'h000, 1'b0, 14'd100, 10'h00A, 3'b110},  // R5 mode 00 tcp bad
        '{4'd5, 9'h002, 1'b0, 14'd100, 10'h00A, 3'b000},  // R5 mode 01 tcp bad
        '{4'd5, 9'h002, 1'b0, 14'd100, 10'h006, 3'b110},  // R5 mode 01 udp bad
        '{4'd5, 9'h004, 1'b0, 14'd100, 10'h006, 3'b000},  // R5 mode 10 udp bad
        '{4'd5, 9'h006, 1'b0, 14'd100, 10'h00A, 3'b110},  // R5 mode 11 tcp bad
        '{4'd6, 9'h020, 1'b0, 14'd100, 10'h300, 3'b000},  // R6 crc+dribble, crc only
        '{4'd6, 9'h060, 1'b0, 14'd100, 10'h300, 3'b110},  // R6 crc+dribble, both
        '{4'd7, 9'h100, 1'b1, 14'd100, 10'h200, 3'b010},  // R7 drop reported
        '{4'd7, 9'h100, 1'b0, 14'd100, 10'h200, 3'b000},  // R7 short descriptors
        '{4'd8, 9'h001, 1'b0, 14'd100, 10'h001, 3'b111},  // R8 hi prio to queue 2
        '{4'd8, 9'h000, 1'b0, 14'd100, 10'h001, 3'b110},  // R8 queue 2 disabled
        '{4'd8, 9'h001, 1'b0, 14'd100, 10'h000, 3'b110},  // R8 low prio
        '{4'd8, 9'h101, 1'b1, 14'd100, 10'h201, 3'b011}   // R8 reported drop, queue 2
    };

    logic             clk = 1'b0;
    logic             rst_n;
    logic [8:0]       ctrl_field;
    logic             long_desc_mode;
    logic             eof_valid;
    logic [LEN_W-1:0] frm_len;
    logic [9:0]       st;
    logic             dec_valid, dec_accept, dec_report, dec_queue, drop_pulse;
    logic [CNT_W-1:0] drop_count;

    int n_checks = 0;
    int n_fails  = 0;
    int exp_drops = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    rx_accept_filter #(
        .LEN_W   (LEN_W),
        .MIN_LEN (64),
        .CNT_W   (CNT_W)
    ) dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .ctrl_field     (ctrl_field),
        .long_desc_mode (long_desc_mode),
        .eof_valid      (eof_valid),
        .frm_len        (frm_len),
        .frm_crc_err    (st[9]),
        .frm_dribble    (st[8]),
        .frm_code_viol  (st[7]),
        .frm_fifo_ovf   (st[6]),
        .frm_mac_ctrl   (st[5]),
        .frm_pause      (st[4]),
        .frm_is_tcp     (st[3]),
        .frm_is_udp     (st[2]),
        .frm_csum_bad   (st[1]),
        .frm_hi_prio    (st[0]),
        .dec_valid      (dec_valid),
        .dec_accept     (dec_accept),
        .dec_report     (dec_report),
        .dec_queue      (dec_queue),
        .drop_pulse     (drop_pulse),
        .drop_count     (drop_count)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Drive one frame end at a negedge; sample the decision at the next one
    task automatic send(input logic [8:0] cf, input logic lng,
                        input logic [LEN_W-1:0] len, input logic [9:0] s);
        @(negedge clk);
        ctrl_field = cf; long_desc_mode = lng; frm_len = len; st = s;
        eof_valid = 1'b1;
        @(negedge clk);
        eof_valid = 1'b0;
    endtask

    initial begin
        rst_n = 1'b0; ctrl_field = '0; long_desc_mode = 1'b0;
        eof_valid = 1'b0; frm_len = '0; st = '0;
        repeat (3) @(negedge clk);
        // R11 reset state
        check("R11 reset outputs",
              {dec_valid, dec_accept, dec_report, dec_queue, drop_pulse}, 0);
        check("R11 reset drop_count", drop_count, 0);
        rst_n = 1'b1;

        for (int i = 0; i < NVEC; i++) begin
            send(VECS[i].cf, VECS[i].lng, VECS[i].len, VECS[i].st);
            if (!VECS[i].exp[2]) exp_drops++;
            check($sformatf("R%0d vec%0d valid", VECS[i].req, i), dec_valid, 1);
            check($sformatf("R%0d vec%0d accept/report/queue", VECS[i].req, i),
                  {dec_accept, dec_report, dec_queue}, VECS[i].exp);
            check($sformatf("R10 vec%0d drop_pulse", i), drop_pulse, !VECS[i].exp[2]);
        end
        check("R10 drop_count after table", drop_count, exp_drops);

        // R9 valid lasts one cycle
        @(negedge clk);
        check("R9 valid single cycle", dec_valid, 0);

        // R9 back-to-back strobes, accept then reject
        @(negedge clk);
        ctrl_field = 9'h000; frm_len = 14'd100; st = 10'h000; eof_valid = 1'b1;
        @(negedge clk);
        check("R9 back-to-back first", {dec_valid, dec_accept}, 3);
        st = 10'h200;
        @(negedge clk);
        eof_valid = 1'b0;
        check("R9 back-to-back second", {dec_valid, dec_accept, drop_pulse}, 5);
        exp_drops++;

        // R10 saturation: burst of rejected frames
        @(negedge clk);
        st = 10'h200; eof_valid = 1'b1;
        repeat (12) @(negedge clk);
        eof_valid = 1'b0;
        @(negedge clk);
        check("R10 drop_count saturates", drop_count, 15);

        // R11 reset clears the count
        rst_n = 1'b0;
        @(negedge clk);
        check("R11 reset clears drop_count", drop_count, 0);
        check("R11 reset clears valid", dec_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    // Watchdog: a hung run ends as a failed check
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL R9 watchdog expired actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

endmodule